// File: doc/BRIEF.md
# Unsigned Word Divide Execution Unit

This unit performs the unsigned 32-bit divide of a 64-bit integer pipeline. The issue logic raises `start_i` for one cycle and presents a 32-bit instruction word, two 64-bit source register values, and the current overflow and summary-overflow status bits. The unit first decodes the instruction word. A word that is not the unsigned-word-divide instruction gives a one-cycle illegal pulse and has no other effect. A matching word starts a radix-2 restoring division of the low 32 bits of the two sources, which produces one quotient bit per cycle.

When the division finishes, the unit raises `done_o` for exactly one cycle. In that cycle it presents the zero-extended quotient, the destination register index, the updated status bits and a 4-bit condition field, each with its own write strobe. A zero divisor is detected in the load cycle and gives a defined result of zero without any iterations and without any trap. The unit is not pipelined: while it is busy, further start requests are dropped.

Top module: `udivw_unit`

## Requirements
- R1: A start is accepted only if instruction bits [31:26] equal 31 and bits [9:1] equal 459. With LSB-0 numbering, bit 10 is the overflow-enable flag and bit 0 is the record flag. A start that is not busy but carries any other word sets `illegal_o` for one cycle. It does not set `busy_o` and produces no `done_o` or write strobes.
- R2: `rd_idx_o` equals instruction bits [25:21] of the accepted instruction, and `rd_we_o` is high exactly while `done_o` is high.
- R3: Only bits [31:0] of each source are used, as unsigned values. Bits [63:32] of both sources have no effect on any output.
- R4: `result_o` is the truncated unsigned quotient of the low words. Its bits [63:32] are zero.
- R5: If the low 32 bits of the divisor are zero, `result_o` is 0 and `done_o` is visible after the second rising edge counted from the accepting edge (inclusive).
- R6: If the divisor is nonzero, `done_o` is visible after the 34th rising edge counted from the accepting edge (inclusive). It stays high for one cycle only.
- R7: With overflow-enable set, `ov_o` is 1 for a zero divisor and 0 otherwise. `so_o` is the sampled `so_i` ORed with the new `ov_o`, and `xer_we_o` pulses with `done_o`. With the flag clear, `ov_o` and `so_o` return the `ov_i` and `so_i` sampled at acceptance, and `xer_we_o` stays low.
- R8: With the record flag set, `cr_o` = {LT,GT,EQ,SO} (bit 3 = LT). It compares the low 32 result bits, read as a signed value, against zero, so a quotient of 2^31 or more gives LT. SO copies `so_o`. `cr_we_o` pulses with `done_o`. With the flag clear, `cr_o` is 0 and `cr_we_o` stays low.
- R9: A `start_i` raised while `busy_o` is high is ignored. It changes no result and raises no `illegal_o`.
- R10: After reset, `busy_o`, `done_o`, `illegal_o` and all write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 64 | Dividend register value |
| src_b_i | input | 64 | Divisor register value |
| ov_i | input | 1 | Current overflow bit |
| so_i | input | 1 | Current summary-overflow bit |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle pulse for a non-matching instruction |
| result_o | output | 64 | Zero-extended quotient |
| rd_idx_o | output | 5 | Destination register index |
| rd_we_o | output | 1 | Destination write strobe |
| ov_o | output | 1 | Overflow bit to write |
| so_o | output | 1 | Summary-overflow bit to write |
| xer_we_o | output | 1 | Status-bit write strobe |
| cr_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_we_o | output | 1 | Condition-field write strobe |

## Verification
The bench drives inputs on falling edges and counts rising edges from the accepting edge up to the first falling edge at which `done_o` is seen. The count must be exactly 34 for a nonzero divisor and 2 for a zero divisor. The result, index, status and condition values are compared at that same sample. On the sample that follows, the bench checks that `done_o` and every strobe are low. `illegal_o` is checked one falling edge after the rejected start and checked clear one edge later. The bench then watches a window longer than a full division to confirm that no completion follows.

// File: rtl/udivw_pkg.sv
package udivw_pkg;
   localparam int REG_IDX_W = 5;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_ITER,
      ST_FINAL
   } div_state_e;

   typedef struct packed {
      logic                 legal;
      logic                 ov_en;
      logic                 rec;
      logic [REG_IDX_W-1:0] rd;
   } div_decode_t;
endpackage

// File: rtl/udivw_decode.sv
module udivw_decode
   import udivw_pkg::*;
#(
   parameter int IW       = 32,
   parameter int PRIM_OP  = 31,
   parameter int EXT_OP   = 459
) (
   input  logic [IW-1:0] instr,
   output div_decode_t   dec
);
   localparam int PRIM_W = 6;
   localparam int EXT_W  = 9;

   if (IW != 32) begin : g_bad_iw
      $error("udivw_decode: instruction width must be 32");
   end
   if (PRIM_OP >= (1 << PRIM_W) || EXT_OP >= (1 << EXT_W)) begin : g_bad_op
      $error("udivw_decode: opcode constant does not fit its field");
   end

   logic [PRIM_W-1:0] prim_f;
   logic [EXT_W-1:0]  ext_f;
   logic              unused_src_fields;

   assign prim_f            = instr[31:26];
   assign ext_f             = instr[9:1];
   assign unused_src_fields = ^instr[20:11];

   always_comb begin
      dec.legal = (prim_f == PRIM_W'(PRIM_OP)) && (ext_f == EXT_W'(EXT_OP));
      dec.ov_en = instr[10];
      dec.rec   = instr[0];
      dec.rd    = instr[25:21];
   end
endmodule

// File: rtl/udivw_core.sv
module udivw_core
   import udivw_pkg::*;
#(
   parameter int WLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [WLEN-1:0] dividend,
   input  logic [WLEN-1:0] divisor,
   output logic            busy,
   output logic            done,
   output logic            div_zero,
   output logic [WLEN-1:0] quotient
);
   localparam int CNT_W = $clog2(WLEN);

   if (WLEN < 2) begin : g_bad_w
      $error("udivw_core: WLEN must be at least 2");
   end

   div_state_e        state;
   logic [WLEN-1:0]   dvd_q;
   logic [WLEN-1:0]   dvs_q;
   logic [WLEN-1:0]   rem_q;
   logic [WLEN-1:0]   quo_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              zero_q;

   logic [WLEN:0]     rem_sh;
   logic [WLEN:0]     diff;
   logic              qbit;
   logic [WLEN-1:0]   rem_nx;

   always_comb begin
      rem_sh = {rem_q, quo_q[WLEN-1]};
      diff   = rem_sh - {1'b0, dvs_q};
      qbit   = ~diff[WLEN];
      rem_nx = qbit ? diff[WLEN-1:0] : rem_sh[WLEN-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         dvd_q  <= '0;
         dvs_q  <= '0;
         rem_q  <= '0;
         quo_q  <= '0;
         cnt_q  <= '0;
         zero_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (go) begin
                  dvd_q <= dividend;
                  dvs_q <= divisor;
                  state <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               zero_q <= (dvs_q == '0);
               rem_q  <= '0;
               cnt_q  <= '0;
               if (dvs_q == '0) begin
                  quo_q <= '0;
                  state <= ST_FINAL;
               end else begin
                  quo_q <= dvd_q;
                  state <= ST_ITER;
               end
            end
            ST_ITER: begin
               rem_q <= rem_nx;
               quo_q <= {quo_q[WLEN-2:0], qbit};
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(WLEN - 1)) state <= ST_FINAL;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_FINAL);
   assign div_zero = zero_q;
   assign quotient = quo_q;

   // R5: zero divisor skips the iterations
   assert_zero_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy && divisor == '0) |=> ##1 done);

   // R4: restoring remainder ends below the divisor
   assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !zero_q) |-> (rem_q < dvs_q));

   // R6: no completion straight after acceptance
   assert_no_early_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy) |=> !done);
endmodule

// File: rtl/udivw_status.sv
module udivw_status #(
   parameter int WLEN = 32
) (
   input  logic            ov_en,
   input  logic            rec,
   input  logic            ov_in,
   input  logic            so_in,
   input  logic            div_zero,
   input  logic [WLEN-1:0] quo_low,
   output logic            ov_out,
   output logic            so_out,
   output logic [3:0]      cr_out
);
   logic neg, zero;

   always_comb begin
      neg    = quo_low[WLEN-1];
      zero   = (quo_low == '0);
      ov_out = ov_en ? div_zero : ov_in;
      so_out = ov_en ? (so_in | div_zero) : so_in;
      cr_out = rec ? {neg, ~neg & ~zero, zero, so_out} : 4'b0000;
   end
endmodule

// File: rtl/udivw_unit.sv
module udivw_unit
   import udivw_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int WLEN    = 32,
   parameter int IW      = 32,
   parameter int PRIM_OP = 31,
   parameter int EXT_OP  = 459
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [IW-1:0]        instr_i,
   input  logic [XLEN-1:0]      src_a_i,
   input  logic [XLEN-1:0]      src_b_i,
   input  logic                 ov_i,
   input  logic                 so_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 illegal_o,
   output logic [XLEN-1:0]      result_o,
   output logic [REG_IDX_W-1:0] rd_idx_o,
   output logic                 rd_we_o,
   output logic                 ov_o,
   output logic                 so_o,
   output logic                 xer_we_o,
   output logic [3:0]           cr_o,
   output logic                 cr_we_o
);
   if (XLEN < WLEN) begin : g_bad_xlen
      $error("udivw_unit: XLEN must not be below WLEN");
   end

   div_decode_t      dec;
   logic             accept;
   logic             illegal_q;
   logic             oe_q, rc_q, ov_q, so_q;
   logic [REG_IDX_W-1:0] rd_q;
   logic             busy, done, div_zero;
   logic [WLEN-1:0]  quo;
   logic             st_ov, st_so;
   logic [3:0]       st_cr;

   udivw_decode #(.IW(IW), .PRIM_OP(PRIM_OP), .EXT_OP(EXT_OP)) u_dec (
      .instr (instr_i),
      .dec   (dec)
   );

   assign accept = start_i && !busy && dec.legal;

   udivw_core #(.WLEN(WLEN)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (accept),
      .dividend (src_a_i[WLEN-1:0]),
      .divisor  (src_b_i[WLEN-1:0]),
      .busy     (busy),
      .done     (done),
      .div_zero (div_zero),
      .quotient (quo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         illegal_q <= 1'b0;
         oe_q      <= 1'b0;
         rc_q      <= 1'b0;
         ov_q      <= 1'b0;
         so_q      <= 1'b0;
         rd_q      <= '0;
      end else begin
         illegal_q <= start_i && !busy && !dec.legal;
         if (accept) begin
            oe_q <= dec.ov_en;
            rc_q <= dec.rec;
            ov_q <= ov_i;
            so_q <= so_i;
            rd_q <= dec.rd;
         end
      end
   end

   udivw_status #(.WLEN(WLEN)) u_stat (
      .ov_en    (oe_q),
      .rec      (rc_q),
      .ov_in    (ov_q),
      .so_in    (so_q),
      .div_zero (div_zero),
      .quo_low  (quo),
      .ov_out   (st_ov),
      .so_out   (st_so),
      .cr_out   (st_cr)
   );

   if (XLEN > WLEN) begin : g_zext
      logic unused_hi;
      assign unused_hi = ^{src_a_i[XLEN-1:WLEN], src_b_i[XLEN-1:WLEN]};
      assign result_o  = {{(XLEN-WLEN){1'b0}}, quo};
   end else begin : g_same
      assign result_o = quo;
   end

   assign busy_o    = busy;
   assign done_o    = done;
   assign illegal_o = illegal_q;
   assign rd_idx_o  = rd_q;
   assign rd_we_o   = done;
   assign ov_o      = st_ov;
   assign so_o      = st_so;
   assign xer_we_o  = done && oe_q;
   assign cr_o      = st_cr;
   assign cr_we_o   = done && rc_q;

   // R6: completion pulse lasts one cycle
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4: upper result half is zero on completion
   assert_zext_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (result_o[XLEN-1:WLEN] == '0));

   // R9: start while busy is not flagged as illegal
   assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> !illegal_o);

   // R7: written overflow implies sticky summary set
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xer_we_o && ov_o) |-> so_o);

   // R8: exactly one of LT/GT/EQ on a condition write
   assert_cr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we_o |-> ($countones(cr_o[3:1]) == 1));

   // R1: rejected instruction starts nothing
   assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (!busy_o && !rd_we_o));
endmodule

// File: tb/udivw_unit_test.sv
module udivw_unit_test;
   localparam int PERIOD = 20;
   localparam int NV     = 7;

   localparam logic [63:0] VA [NV] = '{
      64'hFFFFFFFF_00000064, 64'h00000000_80000000, 64'h00000000_00000005,
      64'h00000000_00000007, 64'h00000000_FFFFFFFF, 64'h00000000_FFFFFFFF,
      64'hABCDEF01_DEADBEEF};
   localparam logic [63:0] VB [NV] = '{
      64'h12345678_00000007, 64'h00000000_00000001, 64'hFFFFFFFF_00000000,
      64'h00000000_00000009, 64'h00000000_FFFFFFFF, 64'h00000000_00000002,
      64'hFFFFFFFF_00010000};
   localparam logic [NV-1:0] VOE = 7'b0010101;
   localparam logic [NV-1:0] VRC = 7'b0101111;
   localparam logic [NV-1:0] VOV = 7'b0001001;
   localparam logic [NV-1:0] VSO = 7'b1011000;

   logic        clk = 0, rst_n = 0, start = 0, ov_i = 0, so_i = 0;
   logic [31:0] instr = 0;
   logic [63:0] a = 0, b = 0;
   logic        busy, done, illegal, rd_we, ov_o, so_o, xer_we, cr_we;
   logic [63:0] result;
   logic [4:0]  rd_idx;
   logic [3:0]  cr;

   int errors = 0, checks = 0;

   always #(PERIOD/2) clk = ~clk;

   udivw_unit uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr),
      .src_a_i(a), .src_b_i(b), .ov_i(ov_i), .so_i(so_i),
      .busy_o(busy), .done_o(done), .illegal_o(illegal), .result_o(result),
      .rd_idx_o(rd_idx), .rd_we_o(rd_we), .ov_o(ov_o), .so_o(so_o),
      .xer_we_o(xer_we), .cr_o(cr), .cr_we_o(cr_we));

   function automatic logic [31:0] enc(input logic [4:0] rd, input logic oe, input logic rc);
      return {6'd31, rd, 5'd1, 5'd2, oe, 9'd459, rc};
   endfunction

   task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_done(output int cyc);
      cyc = 1;
      @(negedge clk);
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic run_vec(input logic [63:0] va, input logic [63:0] vb, input logic oe,
                          input logic rc, input logic vov, input logic vso, input logic [4:0] rd);
      logic [31:0] q;
      logic        z, e_ov, e_so;
      logic [3:0]  e_cr;
      int          cyc;
      z    = (vb[31:0] == 0);
      q    = z ? 32'd0 : va[31:0] / vb[31:0];
      e_ov = oe ? z : vov;
      e_so = oe ? (vso | z) : vso;
      e_cr = rc ? {q[31], !q[31] && q != 0, q == 0, e_so} : 4'b0;
      @(negedge clk);
      instr = enc(rd, oe, rc); a = va; b = vb; ov_i = vov; so_i = vso; start = 1;
      @(negedge clk);
      start = 0; a = ~va; b = ~vb; ov_i = ~vov; so_i = ~vso;
      cyc = 1;
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      check(cyc == (z ? 2 : 34), z ? "R5 latency" : "R6 latency", 64'(cyc), 64'(z ? 2 : 34));
      check(result == {32'd0, q}, "R4 R3 quotient", result, {32'd0, q});
      check(rd_idx == rd && rd_we, "R2 destination", {58'd0, rd_we, rd_idx}, {58'd0, 1'b1, rd});
      check({ov_o, so_o, xer_we} == {e_ov, e_so, oe}, "R7 status",
            {61'd0, ov_o, so_o, xer_we}, {61'd0, e_ov, e_so, oe});
      check({cr, cr_we} == {e_cr, rc}, "R8 condition", {59'd0, cr, cr_we}, {59'd0, e_cr, rc});
      @(negedge clk);
      check(!done && !rd_we && !xer_we && !cr_we, "R6 one-cycle done",
            {60'd0, done, rd_we, xer_we, cr_we}, 64'd0);
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(!busy && !done && !illegal && !rd_we && !xer_we && !cr_we, "R10 reset",
            {58'd0, busy, done, illegal, rd_we, xer_we, cr_we}, 64'd0);
      rst_n = 1;

      for (int i = 0; i < NV; i++)
         run_vec(VA[i], VB[i], VOE[i], VRC[i], VOV[i], VSO[i], 5'(i + 3));

      // R3: upper halves differ, same low words as an earlier vector
      run_vec(64'h00000000_00000064, 64'h00000000_00000007, 1'b1, 1'b1, 1'b0, 1'b0, 5'd31);

      // R1: wrong extended opcode
      @(negedge clk);
      instr = enc(5'd4, 1'b1, 1'b1) ^ 32'h0000_0002; a = 64'd9; b = 64'd3; start = 1;
      @(negedge clk);
      start = 0;
      check(illegal && !busy, "R1 illegal pulse", {62'd0, illegal, busy}, 64'd2);
      @(negedge clk);
      check(!illegal, "R1 illegal clears", {63'd0, illegal}, 64'd0);
      begin
         logic seen = 0;
         repeat (40) begin
            @(negedge clk);
            if (done || rd_we || xer_we || cr_we || busy) seen = 1;
         end
         check(!seen, "R1 no writes", {63'd0, seen}, 64'd0);
      end

      // R1: wrong primary opcode
      @(negedge clk);
      instr = enc(5'd4, 1'b0, 1'b0) ^ 32'h0400_0000; start = 1;
      @(negedge clk);
      start = 0;
      check(illegal && !busy, "R1 primary mismatch", {62'd0, illegal, busy}, 64'd2);

      // R9: start while busy is ignored
      @(negedge clk);
      instr = enc(5'd9, 1'b0, 1'b1); a = 64'd1000; b = 64'd10; start = 1;
      @(negedge clk);
      start = 0;
      repeat (3) @(negedge clk);
      instr = enc(5'd17, 1'b1, 1'b0); a = 64'd77; b = 64'd0; start = 1;
      @(negedge clk);
      check(!illegal, "R9 no illegal when busy", {63'd0, illegal}, 64'd0);
      instr = 32'h0; start = 1;
      @(negedge clk);
      start = 0;
      check(!illegal, "R9 bad word when busy", {63'd0, illegal}, 64'd0);
      wait_done(cyc);
      check(result == 64'd100 && rd_idx == 5'd9 && !xer_we && cr_we, "R9 first op kept",
            result, 64'd100);
      @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule